// File: doc/BRIEF.md
# Byte-wide ROM doubleword read assembler

This block sits on the target side of a 32-bit bus and serves reads from an 8-bit external ROM placed in a programmable expansion window. Each address phase is compared against the window base and the bus command. A matching read is claimed. If the requested doubleword is not already held, the block fetches it as four byte reads on a simple ROM port and packs the bytes into a 32-bit word.

A fetch lasts longer than the bus will wait, so the bus is told to retry. The master reissues the same read, and once the word is held the reissued read completes with data. A read to another doubleword starts a new fetch. Writes to the window are never claimed.

The claim decision is registered twice. It therefore appears in the second cycle after the address phase, which is medium-speed select timing.

Top module: `xrom_dword_reader`

## Requirements
- R1: A claim pulse is given only for an address phase where `bus_start_i` is high, `bus_addr_i[31:ROM_AW]` equals `win_base_i`, and `bus_cmd_i` is a memory read code (4'h6, 4'hC or 4'hE). Any other combination gives no claim.
- R2: A claim is a one-cycle pulse on `claim_o` in the second cycle after the address-phase cycle. It comes with exactly one of `retry_o` or `ack_o`. Neither of those is ever high without `claim_o`.
- R3: Write commands (4'h7, 4'hF) to the window are not claimed. They cause no ROM activity, and they leave the held doubleword usable.
- R4: A claimed read for which no completed doubleword with the same index is held answers with retry and starts a fetch.
- R5: A fetch holds `rom_rd_o` high for exactly 4*WAIT_CYCLES cycles. It presents offsets 0, 1, 2 and 3 of the doubleword on `rom_addr_o`, in that order, for WAIT_CYCLES cycles each. At 5 wait cycles the fetch takes 20 cycles.
- R6: The byte at offset 0 lands in bits 7:0 of the word, offset 1 in 15:8, offset 2 in 23:16 and offset 3 in 31:24.
- R7: While a fetch is running, every claimed read answers with retry and the running fetch continues unchanged.
- R8: A claimed read whose index (`bus_addr_i[ROM_AW-1:2]`) matches a completed held doubleword answers with `ack_o` and the packed data. It starts no ROM activity.
- R9: A read to a different doubleword discards the held word. A later read of the old address retries again.
- R10: After reset, all outputs are low and no doubleword is held.
- R11: `rdata_o` is zero in every cycle where `ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start_i | input | 1 | High during the address-phase cycle |
| bus_addr_i | input | 30 | Doubleword address, bits 31:2 |
| bus_cmd_i | input | 4 | Bus command code |
| win_base_i | input | 32-ROM_AW | Programmed window base, address bits 31:ROM_AW |
| claim_o | output | 1 | Device-select pulse, medium timing |
| retry_o | output | 1 | Claimed cycle must be retried |
| ack_o | output | 1 | Claimed cycle completes with data |
| rdata_o | output | 32 | Packed doubleword, valid with ack_o |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_addr_o | output | ROM_AW | ROM byte address |
| rom_data_i | input | 8 | ROM read data |

## Verification
A table of address phases varies three things: start strobe present or absent, upper address inside or outside the window, and command read, write or other. This shows that the claim depends on all three together. Directed sequences then try a first read (miss), repeat reads during a fetch (same and different index), a repeat after completion (hit, including nonzero low address bits) and a switch to another doubleword and back. These separate the retry caused by a busy fetch, the retry caused by a miss and the completion from the held word. A monitor on the ROM port records every fetch cycle and checks the byte order, the dwell per byte and the total length. A write placed between a fill and its reread confirms that writes change nothing.

// File: rtl/xrd_pkg.sv
package xrd_pkg;

    localparam logic [3:0] CMD_MEM_RD      = 4'h6;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;

    function automatic logic is_rom_read(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) ||
               (cmd == CMD_MEM_RD_LINE);
    endfunction

endpackage

// File: rtl/xrd_window_match.sv
module xrd_window_match #(
    parameter int ROM_AW = 12
) (
    input  logic                start_i,
    input  logic [31:2]         addr_i,
    input  logic [3:0]          cmd_i,
    input  logic [31:ROM_AW]    base_i,
    output logic                hit_o,
    output logic [ROM_AW-3:0]   idx_o
);
    import xrd_pkg::*;

    always_comb begin
        hit_o = start_i && (addr_i[31:ROM_AW] == base_i) && is_rom_read(cmd_i);
        idx_o = addr_i[ROM_AW-1:2];
    end

endmodule

// File: rtl/xrd_fetch_seq.sv
module xrd_fetch_seq #(
    parameter int ROM_AW      = 12,
    parameter int WAIT_CYCLES = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ROM_AW-3:0]   start_idx_i,
    input  logic [7:0]          rom_data_i,
    output logic                busy_o,
    output logic                held_vld_o,
    output logic [ROM_AW-3:0]   held_idx_o,
    output logic [31:0]         dword_o,
    output logic                rom_rd_o,
    output logic [ROM_AW-1:0]   rom_addr_o
);
    localparam int IW  = ROM_AW - 2;
    localparam int WCW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [WCW-1:0] WLAST = WCW'(WAIT_CYCLES - 1);

    typedef struct packed {
        logic           busy;
        logic [1:0]     byte_sel;
        logic [WCW-1:0] wcnt;
        logic [31:0]    pack;
        logic [IW-1:0]  idx;
        logic           vld;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy     = 1'b1;
            s_d.byte_sel = 2'd0;
            s_d.wcnt     = '0;
            s_d.vld      = 1'b0;
            s_d.idx      = start_idx_i;
        end else if (s_q.busy) begin
            if (s_q.wcnt == WLAST) begin
                s_d.pack[{s_q.byte_sel, 3'b000} +: 8] = rom_data_i;
                s_d.wcnt = '0;
                if (s_q.byte_sel == 2'd3) begin
                    s_d.busy = 1'b0;
                    s_d.vld  = 1'b1;
                end else begin
                    s_d.byte_sel = s_q.byte_sel + 2'd1;
                end
            end else begin
                s_d.wcnt = s_q.wcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        busy_o     = s_q.busy;
        held_vld_o = s_q.vld;
        held_idx_o = s_q.idx;
        dword_o    = s_q.pack;
        rom_rd_o   = s_q.busy;
        rom_addr_o = {s_q.idx, s_q.byte_sel};
    end

endmodule

// File: rtl/xrom_dword_reader.sv
module xrom_dword_reader #(
    parameter int ROM_AW      = 12,
    parameter int WAIT_CYCLES = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_start_i,
    input  logic [31:2]         bus_addr_i,
    input  logic [3:0]          bus_cmd_i,
    input  logic [31:ROM_AW]    win_base_i,
    output logic                claim_o,
    output logic                retry_o,
    output logic                ack_o,
    output logic [31:0]         rdata_o,
    output logic                rom_rd_o,
    output logic [ROM_AW-1:0]   rom_addr_o,
    input  logic [7:0]          rom_data_i
);
    localparam int IW = ROM_AW - 2;

    typedef struct packed {
        logic          s1_claim;
        logic [IW-1:0] s1_idx;
        logic          claim;
        logic          retry;
        logic          ack;
        logic [31:0]   data;
    } rsp_t;

    rsp_t r_d, r_q;

    logic          dec_hit;
    logic [IW-1:0] dec_idx;
    logic          f_busy, f_vld, f_start;
    logic [IW-1:0] f_idx;
    logic [31:0]   f_dword;

    xrd_window_match #(.ROM_AW(ROM_AW)) u_match (
        .start_i (bus_start_i),
        .addr_i  (bus_addr_i),
        .cmd_i   (bus_cmd_i),
        .base_i  (win_base_i),
        .hit_o   (dec_hit),
        .idx_o   (dec_idx)
    );

    xrd_fetch_seq #(.ROM_AW(ROM_AW), .WAIT_CYCLES(WAIT_CYCLES)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (f_start),
        .start_idx_i (r_q.s1_idx),
        .rom_data_i  (rom_data_i),
        .busy_o      (f_busy),
        .held_vld_o  (f_vld),
        .held_idx_o  (f_idx),
        .dword_o     (f_dword),
        .rom_rd_o    (rom_rd_o),
        .rom_addr_o  (rom_addr_o)
    );

    always_comb begin
        logic held_match;
        held_match   = f_vld && (f_idx == r_q.s1_idx);
        f_start      = r_q.s1_claim && !f_busy && !held_match;

        r_d          = r_q;
        r_d.s1_claim = dec_hit;
        r_d.s1_idx   = dec_idx;
        r_d.claim    = r_q.s1_claim;
        r_d.ack      = r_q.s1_claim && !f_busy && held_match;
        r_d.retry    = r_q.s1_claim && !(!f_busy && held_match);
        r_d.data     = r_d.ack ? f_dword : 32'h0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        claim_o = r_q.claim;
        retry_o = r_q.retry;
        ack_o   = r_q.ack;
        rdata_o = r_q.data;
    end

endmodule

// File: rtl/xrd_checker.sv
module xrd_checker #(
    parameter int ROM_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_start_i,
    input logic [31:2]       bus_addr_i,
    input logic [3:0]        bus_cmd_i,
    input logic [31:ROM_AW]  win_base_i,
    input logic              claim_o,
    input logic              retry_o,
    input logic              ack_o,
    input logic              rom_rd_o,
    input logic [ROM_AW-1:0] rom_addr_o
);
    import xrd_pkg::*;

    // R1 / R3: a claim traces back to a start, in-window address and read command
    assert_claim_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> ($past(bus_start_i, 2) && is_rom_read($past(bus_cmd_i, 2)) &&
                     ($past(bus_addr_i[31:ROM_AW], 2) == $past(win_base_i, 2))));

    // R2: a claim carries exactly one of retry / ack
    assert_claim_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (retry_o ^ ack_o));

    // R2: no answer without a claim
    assert_no_orphan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_o |-> (!retry_o && !ack_o));

    // R5: a fetch begins at offset 0
    assert_fetch_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_rd_o) |-> (rom_addr_o[1:0] == 2'd0));

    // R5: inside a fetch the byte address only steps by one
    assert_fetch_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd_o && $past(rom_rd_o) && (rom_addr_o != $past(rom_addr_o)))
            |-> (rom_addr_o == $past(rom_addr_o) + 1'b1));

    // R8: completing from the held word leaves the ROM idle
    assert_hit_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !rom_rd_o);

endmodule

bind xrom_dword_reader xrd_checker #(.ROM_AW(ROM_AW)) u_xrd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_start_i (bus_start_i),
    .bus_addr_i  (bus_addr_i),
    .bus_cmd_i   (bus_cmd_i),
    .win_base_i  (win_base_i),
    .claim_o     (claim_o),
    .retry_o     (retry_o),
    .ack_o       (ack_o),
    .rom_rd_o    (rom_rd_o),
    .rom_addr_o  (rom_addr_o)
);

// File: tb/test_xrom_dword_reader.sv
`timescale 1ns/1ps
module test_xrom_dword_reader;
    localparam int ROM_AW = 12;
    localparam int WAIT_CYCLES = 5;
    localparam logic [31:ROM_AW] BASE = 20'hC0DE0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_start = 1'b0;
    logic [31:2] bus_addr = '0;
    logic [3:0] bus_cmd = 4'h0;
    logic claim, retry, ack, rom_rd;
    logic [31:0] rdata;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0] rom_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h5A;
    endfunction

    always_comb rom_data = rom_byte(rom_addr);

    xrom_dword_reader #(.ROM_AW(ROM_AW), .WAIT_CYCLES(WAIT_CYCLES)) i_xrom_dword_reader (
        .clk(clk), .rst_n(rst_n), .bus_start_i(bus_start), .bus_addr_i(bus_addr),
        .bus_cmd_i(bus_cmd), .win_base_i(BASE), .claim_o(claim), .retry_o(retry),
        .ack_o(ack), .rdata_o(rdata), .rom_rd_o(rom_rd), .rom_addr_o(rom_addr),
        .rom_data_i(rom_data)
    );

    // ROM port monitor
    logic [ROM_AW-1:0] trace [512];
    int tr_n = 0;
    always @(negedge clk) begin
        if (rom_rd) begin
            trace[tr_n % 512] = rom_addr;
            tr_n = tr_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic s_claim, s_retry, s_ack;
    logic [31:0] s_data;

    // address phase, then sample the response two cycles later
    task automatic bus_op(input logic start, input logic [31:0] a, input logic [3:0] c);
        @(negedge clk);
        bus_start = start; bus_addr = a[31:2]; bus_cmd = c;
        @(negedge clk);
        bus_start = 1'b0;
        @(negedge clk);
        s_claim = claim; s_retry = retry; s_ack = ack; s_data = rdata;
    endtask

    task automatic wait_idle();
        while (rom_rd) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_word(input logic [ROM_AW-1:0] off);
        logic [ROM_AW-1:0] b;
        b = {off[ROM_AW-1:2], 2'b00};
        return {rom_byte(b + 3), rom_byte(b + 2), rom_byte(b + 1), rom_byte(b)};
    endfunction

    typedef struct packed {
        logic        start;
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic        claim;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{1'b1, 32'hC0DE0100, 4'h6, 1'b1},
        '{1'b1, 32'hC0DE0104, 4'h7, 1'b0},
        '{1'b1, 32'hC0DE1104, 4'h6, 1'b0},
        '{1'b0, 32'hC0DE0108, 4'h6, 1'b0},
        '{1'b1, 32'hC0DE010C, 4'hC, 1'b1},
        '{1'b1, 32'hC0DE0110, 4'hE, 1'b1},
        '{1'b1, 32'hC0DE0114, 4'hF, 1'b0},
        '{1'b1, 32'hC0DE0118, 4'h2, 1'b0},
        '{1'b1, 32'h00000118, 4'h6, 1'b0}
    };

    localparam logic [31:0] A_ADDR = {BASE, 12'h040};
    localparam logic [31:0] B_ADDR = {BASE, 12'h080};

    initial begin
        int n0;
        bit seq_ok;
        repeat (4) @(negedge clk);
        // R10: reset state
        check({claim, retry, ack, rom_rd} == 4'b0 && rdata == 0, "R10",
              {claim, retry, ack, rom_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3 / R4 decode table
        foreach (VEC[i]) begin
            n0 = tr_n;
            bus_op(VEC[i].start, VEC[i].addr, VEC[i].cmd);
            check(s_claim == VEC[i].claim, "R1", s_claim, VEC[i].claim);
            check(s_retry == VEC[i].claim && !s_ack, "R4", {s_retry, s_ack},
                  {VEC[i].claim, 1'b0});
            check(s_ack || s_data == 0, "R11", s_data, 0);
        end
        wait_idle();

        // R4 / R7 / R5 / R6: fill A, disturb it during the fetch
        n0 = tr_n;
        bus_op(1'b1, A_ADDR, 4'h6);
        check(s_claim && s_retry && !s_ack, "R4", {s_claim, s_retry, s_ack}, 3'b110);
        bus_op(1'b1, A_ADDR, 4'h6);
        check(s_claim && s_retry && !s_ack, "R7", {s_claim, s_retry, s_ack}, 3'b110);
        bus_op(1'b1, B_ADDR | 32'h1, 4'hC);
        check(s_claim && s_retry && !s_ack, "R7", {s_claim, s_retry, s_ack}, 3'b110);
        wait_idle();
        check(tr_n - n0 == 4 * WAIT_CYCLES, "R5", tr_n - n0, 4 * WAIT_CYCLES);
        seq_ok = 1'b1;
        for (int k = 0; k < 4 * WAIT_CYCLES; k++)
            if (trace[(n0 + k) % 512] != A_ADDR[ROM_AW-1:0] + ROM_AW'(k / WAIT_CYCLES))
                seq_ok = 1'b0;
        check(seq_ok, "R7", seq_ok, 1);

        // R8 / R6: reissue hits, low address bits ignored
        n0 = tr_n;
        bus_op(1'b1, A_ADDR | 32'h3, 4'h6);
        check(s_claim && s_ack && !s_retry, "R8", {s_claim, s_retry, s_ack}, 3'b101);
        check(s_data == exp_word(A_ADDR[ROM_AW-1:0]), "R6", s_data,
              exp_word(A_ADDR[ROM_AW-1:0]));
        repeat (4) @(negedge clk);
        check(tr_n == n0, "R8", tr_n - n0, 0);

        // R3: write to a held address changes nothing
        bus_op(1'b1, A_ADDR, 4'h7);
        check(!s_claim && !s_retry && !s_ack, "R3", {s_claim, s_retry, s_ack}, 0);
        repeat (4) @(negedge clk);
        check(tr_n == n0, "R3", tr_n - n0, 0);
        bus_op(1'b1, A_ADDR, 4'hE);
        check(s_ack && s_data == exp_word(A_ADDR[ROM_AW-1:0]), "R3", s_data,
              exp_word(A_ADDR[ROM_AW-1:0]));

        // R9: switch to B, then A misses again
        bus_op(1'b1, B_ADDR, 4'h6);
        check(s_retry && !s_ack, "R9", {s_retry, s_ack}, 2'b10);
        wait_idle();
        bus_op(1'b1, B_ADDR, 4'h6);
        check(s_ack && s_data == exp_word(B_ADDR[ROM_AW-1:0]), "R6", s_data,
              exp_word(B_ADDR[ROM_AW-1:0]));
        bus_op(1'b1, A_ADDR, 4'h6);
        check(s_retry && !s_ack && s_data == 0, "R9", {s_retry, s_ack}, 2'b10);
        check(s_data == 0, "R11", s_data, 0);
        wait_idle();
        bus_op(1'b1, A_ADDR, 4'h6);
        check(s_ack && s_data == exp_word(A_ADDR[ROM_AW-1:0]), "R2", s_data,
              exp_word(A_ADDR[ROM_AW-1:0]));
        @(negedge clk);
        check(!claim && !ack && !retry, "R2", {claim, retry, ack}, 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule